// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives words from a synchronous serial link on which an external master drives the clock. The serial clock and data lines are brought into the system clock domain through a two-flop synchronizer. Each rising edge of the serial clock shifts one data bit into a shift register, least significant bit first. When the last bit of a word arrives, the word moves into a holding register and a receive-complete flag is set. Software then reads the status register and the data register.

A word is 8 or 9 bits long. In 9-bit mode the extra bit appears in the status register, and the data register keeps the low byte. An optional interrupt follows the receive-complete flag. While the idle input is high, that interrupt also drives a wake output, so a word can finish while the core sleeps and then bring it back. A word that completes while the previous one is still unread sets a sticky overrun error. Only clearing the continuous-receive enable removes that error.

Register map (`reg_addr`): 0 = control (read/write), 1 = status (read only), 2 = data (read only, reading it has a side effect), 3 reads as zero. Control bits: [0] port enable, [1] synchronous mode, [2] clock master select, [3] continuous-receive enable, [4] single-receive enable, [5] 9-bit mode, [6] interrupt enable. Status bits: [0] receive complete, [1] overrun, [2] ninth data bit. The remaining status bits read as zero.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and `irq` and `wake` are low.
- R2: Words are received only while control bits [0], [1] and [3] are set and bit [2] is clear. In any other setting, serial clock edges set no status bit, and the bit counter stays at zero.
- R3: Control bit [4] has no effect. If it is set while bit [3] is clear, nothing is received. If bit [3] is set, reception works whatever bit [4] holds.
- R4: Data is sampled on rising edges of the serial clock, least significant bit first. In 8-bit mode, after the 8th edge the data register holds the word and status bit [0] reads 1. The data register changes only when a word completes.
- R5: With control bit [5] set, a word is 9 bits long. The 9th received bit reads in status bit [2], and the low 8 bits read in the data register.
- R6: Reading address 2 clears status bit [0]. The flag never falls without such a read.
- R7: If a word completes while status bit [0] is set and no data read happens in that cycle, status bit [1] is set and the held data is kept. While bit [1] stays set, later words are discarded.
- R8: While control bit [3] is clear, status bit [1] is cleared. Once bit [3] is set again, reception resumes.
- R9: `irq` is high exactly when status bit [0] and control bit [6] are both set.
- R10: Reception continues while `idle_in` is high. `wake` is high when `idle_in` and `irq` are both high.
- R11: If a data read and a word completion fall in the same cycle, the read returns the old word. The new word is stored, status bit [0] stays set, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the external master |
| sdat_in | input | 1 | Serial data |
| idle_in | input | 1 | Core is in a low-power or idle state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 7 | Write data (control register) |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request while idle |

## Verification
A software read of the data register and the completion of the next word can fall in the same system clock cycle. That cycle decides whether the flag clears, stays set or turns into an overrun. The bench first leaves one word unread. It then places the data read strobe in the exact cycle in which the synchronized rising edge of the final bit is detected, two system clocks after that edge reaches the pins. It judges the result at the ports: the read must return the old word, the data register must then hold the new word, and the status must show the flag set with no overrun.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_MAX = DATA_W + 1;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic rx_ie;
    logic wide9;
    logic single_rx;
    logic cont_rx;
    logic clk_master;
    logic sync_mode;
    logic port_en;
  } ctrl_t;
endpackage

// File: rtl/sync_rx_cdc.sv
module sync_rx_cdc #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdat_in,
  output logic rise,
  output logic bit_o
);
  logic [STAGES:0]   clk_pipe_q, clk_pipe_d;
  logic [STAGES-1:0] dat_pipe_q, dat_pipe_d;

  always_comb begin
    clk_pipe_d = {clk_pipe_q[STAGES-1:0], sclk_in};
    dat_pipe_d = {dat_pipe_q[STAGES-2:0], sdat_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      dat_pipe_q <= '0;
    end else begin
      clk_pipe_q <= clk_pipe_d;
      dat_pipe_q <= dat_pipe_d;
    end
  end

  // rising edge seen one stage past the synchronizer
  assign rise  = clk_pipe_q[STAGES-1] & ~clk_pipe_q[STAGES];
  assign bit_o = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int WORD_MAX = 9,
  localparam int CNT_W = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                wide9,
  input  logic                rise,
  input  logic                bit_i,
  output logic                word_done,
  output logic [WORD_MAX-1:0] word
);
  logic [CNT_W-1:0]    cnt_q, cnt_d, last;
  logic [WORD_MAX-1:0] sh_q, sh_d, mask;

  always_comb begin
    last = wide9 ? CNT_W'(WORD_MAX - 1) : CNT_W'(WORD_MAX - 2);
    mask = wide9 ? '1 : {1'b0, {(WORD_MAX-1){1'b1}}};
    cnt_d = cnt_q;
    sh_d = sh_q;
    word_done = 1'b0;
    if (!active) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d[cnt_q] = bit_i;
      if (cnt_q >= last) begin
        word_done = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    word = sh_d & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_MAX - 1)); // R5
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_q == '0); // R2
endmodule

// File: rtl/sync_rx_regs.sv
module sync_rx_regs
  import sync_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [CTRL_W-1:0]   reg_wdata,
  input  logic                word_done,
  input  logic [WORD_MAX-1:0] word,
  input  logic                idle_in,
  output ctrl_t               ctrl_q,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq,
  output logic                wake
);
  ctrl_t               ctrl_d;
  logic [WORD_MAX-1:0] data_q, data_d;
  logic                done_q, done_d, ovr_q, ovr_d;
  logic                rd_data, accept;

  always_comb begin
    rd_data = reg_rd && (reg_addr == A_DATA);
    accept  = word_done && !ovr_q;
    ctrl_d  = (reg_wr && reg_addr == A_CTRL) ? ctrl_t'(reg_wdata) : ctrl_q;
    done_d  = done_q;
    data_d  = data_q;
    ovr_d   = ovr_q;
    if (rd_data) done_d = 1'b0;
    if (accept) begin
      if (done_q && !rd_data) begin
        ovr_d = 1'b1;
      end else begin
        data_d = word;
        done_d = 1'b1;
      end
    end
    if (!ctrl_q.cont_rx) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {1'b0, ctrl_q};
      A_STAT:  reg_rdata = {5'b0, data_q[WORD_MAX-1], ovr_q, done_q};
      A_DATA:  reg_rdata = data_q[DATA_W-1:0];
      default: reg_rdata = '0;
    endcase
  end

  assign irq  = done_q & ctrl_q.rx_ie;
  assign wake = irq & idle_in;

  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(rd_data)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(data_q)); // R4
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(data_q)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && ctrl_q.cont_rx) |=> ovr_q); // R7
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.cont_rx |=> !ovr_q); // R8
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              idle_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              wake
);
  ctrl_t               ctrl;
  logic                rise, bit_s, active, word_done;
  logic [WORD_MAX-1:0] word;

  // slave reception: synchronous port on, external clock, continuous enable
  assign active = ctrl.port_en & ctrl.sync_mode & ~ctrl.clk_master & ctrl.cont_rx;

  sync_rx_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .rise(rise), .bit_o(bit_s));

  sync_rx_shift #(.WORD_MAX(WORD_MAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .wide9(ctrl.wide9),
    .rise(rise), .bit_i(bit_s), .word_done(word_done), .word(word));

  sync_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .word_done(word_done),
    .word(word), .idle_in(idle_in), .ctrl_q(ctrl), .reg_rdata(reg_rdata),
    .irq(irq), .wake(wake));
endmodule

// File: tb/sync_slave_rx_bench.sv
module sync_slave_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_in = 1'b0, sdat_in = 1'b0, idle_in = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [6:0] reg_wdata = 7'd0;
  logic [7:0] reg_rdata;
  logic       irq, wake;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sync_slave_rx u_sync_slave_rx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .idle_in(idle_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .wake(wake));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sclk_in = 1'b0; sdat_in = b;
    repeat (3) @(negedge clk);
    sclk_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
    @(negedge clk); sclk_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); check("R1 ctrl", 16'(v), 16'h00);
    rd_reg(2'd1, v); check("R1 status", 16'(v), 16'h00);
    check("R1 irq/wake", {irq, wake}, 16'h0);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr_ctrl(7'h0F); send_word(9'h0A5, 8);
    rd_reg(2'd1, v); check("R2 master set", 16'(v), 16'h00);
    wr_ctrl(7'h09); send_word(9'h0A5, 8);
    rd_reg(2'd1, v); check("R2 sync clear", 16'(v), 16'h00);
    wr_ctrl(7'h0A); send_word(9'h0A5, 8);
    rd_reg(2'd1, v); check("R2 port off", 16'(v), 16'h00);
  endtask

  task automatic t_single();
    logic [7:0] v;
    wr_ctrl(7'h13); send_word(9'h03C, 8);
    rd_reg(2'd1, v); check("R3 single only", 16'(v), 16'h00);
    wr_ctrl(7'h1B); send_word(9'h03C, 8);
    rd_reg(2'd1, v); check("R3 status", 16'(v), 16'h01);
    rd_reg(2'd2, v); check("R3 data", 16'(v), 16'h3C);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    wr_ctrl(7'h0B); send_word(9'h0A5, 8);
    rd_reg(2'd1, v); check("R4 status", 16'(v), 16'h01);
    rd_reg(2'd2, v); check("R4 data A5", 16'(v), 16'hA5);
    rd_reg(2'd1, v); check("R6 flag cleared", 16'(v), 16'h00);
    send_word(9'h01E, 8);
    rd_reg(2'd2, v); check("R4 data 1E", 16'(v), 16'h1E);
  endtask

  task automatic t_nine();
    logic [7:0] v;
    wr_ctrl(7'h2B); send_word(9'h1C3, 9);
    rd_reg(2'd1, v); check("R5 ninth set", 16'(v), 16'h05);
    rd_reg(2'd2, v); check("R5 low byte", 16'(v), 16'hC3);
    send_word(9'h081, 9);
    rd_reg(2'd1, v); check("R5 ninth clear", 16'(v), 16'h01);
    rd_reg(2'd2, v); check("R5 low byte 2", 16'(v), 16'h81);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wr_ctrl(7'h0B); send_word(9'h011, 8); send_word(9'h022, 8);
    rd_reg(2'd1, v); check("R7 overrun", 16'(v), 16'h03);
    rd_reg(2'd2, v); check("R7 old data kept", 16'(v), 16'h11);
    send_word(9'h033, 8);
    rd_reg(2'd1, v); check("R7 discarded", 16'(v), 16'h02);
    wr_ctrl(7'h03);
    rd_reg(2'd1, v); check("R8 cleared", 16'(v), 16'h00);
    wr_ctrl(7'h0B); send_word(9'h044, 8);
    rd_reg(2'd1, v); check("R8 resume status", 16'(v), 16'h01);
    rd_reg(2'd2, v); check("R8 resume data", 16'(v), 16'h44);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr_ctrl(7'h4B);
    check("R9 irq idle", 16'(irq), 16'h0);
    send_word(9'h055, 8);
    check("R9 irq set", {irq, wake}, 16'h2);
    rd_reg(2'd2, v);
    check("R9 irq cleared", 16'(irq), 16'h0);
    wr_ctrl(7'h0B); send_word(9'h056, 8);
    check("R9 irq disabled", 16'(irq), 16'h0);
    rd_reg(2'd2, v);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    wr_ctrl(7'h4B); idle_in = 1'b1; send_word(9'h09C, 8);
    check("R10 wake", {irq, wake}, 16'h3);
    rd_reg(2'd2, v); check("R10 data", 16'(v), 16'h9C);
    check("R10 wake cleared", 16'(wake), 16'h0);
    idle_in = 1'b0;
  endtask

  task automatic t_collide();
    logic [7:0] v;
    logic [8:0] w = 9'h077;
    wr_ctrl(7'h0B); send_word(9'h066, 8);
    for (int i = 0; i < 7; i++) send_bit(w[i]);
    @(negedge clk); sclk_in = 1'b0; sdat_in = w[7];
    repeat (3) @(negedge clk);
    sclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    check("R11 read old", 16'(v), 16'h66);
    @(negedge clk); sclk_in = 1'b0;
    rd_reg(2'd1, v); check("R11 status", 16'(v), 16'h01);
    rd_reg(2'd2, v); check("R11 new data", 16'(v), 16'h77);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_single();
    t_basic();
    t_nine();
    t_overrun();
    t_irq();
    t_wake();
    t_collide();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule